// File: doc/BRIEF.md
# Memory-Mapped Serial Byte FIFO Bridge

This block sits on a processor's memory-mapped I/O bus as a byte-wide slave and places a receive queue and a transmit queue between software and an external serial transceiver. The receive side accepts bytes from the transceiver's byte stream into a FIFO. Software polls a data-available flag, then reads the oldest byte. The read does not remove the byte. A separate store to a dequeue register removes it. On the transmit side, software checks a space-available flag before it stores a byte, and the transceiver drains the FIFO through a valid/ready handshake. The two queues decouple instruction timing from serial bit timing.

The bus interface accepts one access per cycle. A load is answered on the following cycle, with a read-valid strobe and the byte. A small two-state access machine sequences this response. Its states are BUS_IDLE, where no response is pending, and BUS_RESP, where the captured byte is presented. Transitions: IDLE_TO_RESP on a load request; RESP_TO_RESP on a back-to-back load; RESP_TO_IDLE when no load is issued; IDLE_TO_IDLE otherwise. Five byte registers are decoded within an eight-byte window at a parameterised base address. Each register has a fixed offset and is either load-only or store-only:

| Offset | Access | Function |
|--------|--------|----------|
| 0 | load | Receive FIFO not empty, in bit 0 |
| 1 | load | Oldest receive byte |
| 2 | load | Transmit FIFO not full, in bit 0 |
| 3 | store | Dequeue the receive FIFO |
| 4 | store | Enqueue a transmit byte |

Top module: `serial_mmio_bridge`

## Requirements
- R1: After reset both FIFOs are empty, `tx_valid` is 0 and `bus_rvalid` is 0.
- R2: A load from offset 0 returns 0x01 when the receive FIFO holds at least one byte and 0x00 otherwise. Bits 7..1 always read 0.
- R3: A load from offset 1 returns the oldest receive byte and leaves the FIFO unchanged. When the receive FIFO is empty, it returns 0x00.
- R4: A load from offset 2 returns 0x01 when the transmit FIFO has at least one free entry and 0x00 when it is full. Bits 7..1 always read 0.
- R5: Any store to offset 3 removes the oldest receive byte. Such a store to an empty receive FIFO changes nothing.
- R6: A store to offset 4 appends `bus_wdata` to the transmit FIFO. Such a store to a full transmit FIFO is dropped and changes nothing.
- R7: A byte presented with `rx_valid` is appended to the receive FIFO on that clock edge if, before that edge, the FIFO is not full. Otherwise the byte is dropped.
- R8: `tx_valid` is high exactly when the transmit FIFO is non-empty, and `tx_data` is its oldest byte. The byte is removed on a clock edge where both `tx_valid` and `tx_ready` are high. While `tx_ready` stays low, `tx_data` holds steady.
- R9: Every load gets exactly one response, with `bus_rvalid` high on the next cycle. Loads from offsets 3 to 7, or from outside the window, return 0x00. Stores to offsets 0 to 2, to offsets 5 to 7, or outside the window change nothing.
- R10: Each FIFO delivers bytes in arrival order, including when a push and a pop occur on the same edge.
- R11: Fullness is judged from the state before an edge. On a full FIFO, an incoming byte is dropped even if a pop happens on the same edge. On an empty FIFO, a pop on the same edge as a push is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus access request, one per cycle |
| bus_we | input | 1 | 1 = store, 0 = load |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 8 | Store data |
| bus_rvalid | output | 1 | Load response valid (cycle after request) |
| bus_rdata | output | 8 | Load response byte (0 when not valid) |
| rx_valid | input | 1 | Byte from serial receiver available |
| rx_data | input | 8 | Byte from serial receiver |
| tx_valid | output | 1 | Transmit byte available |
| tx_data | output | 8 | Oldest transmit byte |
| tx_ready | input | 1 | Serial transmitter takes the byte |

## Verification
The bench builds the block with a FIFO depth of 4 and keeps the default base address. With depth 4, both queues reach full within a handful of accesses. That makes the dropped receive byte, the dropped transmit store, the space flag reading zero, and a push and pop on the same edge against a full or empty queue cheap to reach. A behavioural queue model predicts every output on every cycle. It covers each decoded offset, unmapped offsets, and an address outside the window.

// File: rtl/serial_mmio_pkg.sv
package serial_mmio_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        OFF_RX_AVAIL = 3'd0,
        OFF_RX_HEAD  = 3'd1,
        OFF_TX_SPACE = 3'd2,
        OFF_RX_POP   = 3'd3,
        OFF_TX_PUSH  = 3'd4
    } reg_off_e;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [IW-1:0] LAST_IDX = IW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [IW-1:0]    wr_idx, rd_idx;
    logic [CW-1:0]    count;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == FULL_CNT);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = empty ? '0 : mem[rd_idx];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_idx] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_idx <= '0;
            rd_idx <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_idx <= (wr_idx == LAST_IDX) ? '0 : wr_idx + 1'b1;
            end
            if (do_pop) begin
                rd_idx <= (rd_idx == LAST_IDX) ? '0 : rd_idx + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R6 / R7: occupancy never exceeds the depth
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    // R11: a push against a full queue leaves it full and unchanged in size
    assert_full_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full);

    // R5: a pop against an empty queue with no push keeps it empty
    assert_empty_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);

endmodule

// File: rtl/mmio_reg_decode.sv
module mmio_reg_decode
    import serial_mmio_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR = 32'h8000_0000
) (
    input  logic        req,
    input  logic        we,
    input  logic [31:0] addr,
    output logic        ld_rx_avail,
    output logic        ld_rx_head,
    output logic        ld_tx_space,
    output logic        st_rx_pop,
    output logic        st_tx_push
);
    logic       in_window;
    logic [2:0] off;

    assign in_window = (addr[31:3] == BASE_ADDR[31:3]);
    assign off       = addr[2:0];

    always_comb begin
        ld_rx_avail = 1'b0;
        ld_rx_head  = 1'b0;
        ld_tx_space = 1'b0;
        st_rx_pop   = 1'b0;
        st_tx_push  = 1'b0;
        if (req && in_window) begin
            unique case (off)
                OFF_RX_AVAIL: ld_rx_avail = !we;
                OFF_RX_HEAD:  ld_rx_head  = !we;
                OFF_TX_SPACE: ld_tx_space = !we;
                OFF_RX_POP:   st_rx_pop   = we;
                OFF_TX_PUSH:  st_tx_push  = we;
                default:      ;
            endcase
        end
    end

    // R9: at most one register is selected per access
    always_comb begin
        assert_one_select_R9: assert ($onehot0({ld_rx_avail, ld_rx_head,
            ld_tx_space, st_rx_pop, st_tx_push}));
    end

endmodule

// File: rtl/bus_resp_fsm.sv
module bus_resp_fsm
    import serial_mmio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load_req,
    input  logic [7:0]  load_byte,
    output logic        rvalid,
    output logic [7:0]  rdata
);
    bus_state_e state, state_nxt;
    logic [7:0] held;

    always_comb begin
        state_nxt = state;
        unique case (state)
            BUS_IDLE: state_nxt = load_req ? BUS_RESP : BUS_IDLE;
            BUS_RESP: state_nxt = load_req ? BUS_RESP : BUS_IDLE;
            default:  state_nxt = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= BUS_IDLE;
            held  <= '0;
        end else begin
            state <= state_nxt;
            held  <= load_req ? load_byte : '0;
        end
    end

    always_comb begin
        rvalid = 1'b0;
        rdata  = '0;
        unique case (state)
            BUS_IDLE: ;
            BUS_RESP: begin
                rvalid = 1'b1;
                rdata  = held;
            end
            default:  ;
        endcase
    end

    // R9: each response follows a load on the previous cycle
    assert_resp_follows_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load_req |=> rvalid);
    assert_no_spurious_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !load_req |=> !rvalid);

endmodule

// File: rtl/serial_mmio_bridge.sv
module serial_mmio_bridge
    import serial_mmio_pkg::*;
#(
    parameter int unsigned  DEPTH     = 16,
    parameter logic [31:0]  BASE_ADDR = 32'h8000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_req,
    input  logic        bus_we,
    input  logic [31:0] bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic        bus_rvalid,
    output logic [7:0]  bus_rdata,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    input  logic        tx_ready
);
    logic ld_rx_avail, ld_rx_head, ld_tx_space, st_rx_pop, st_tx_push;
    logic rx_empty, rx_full, tx_empty, tx_full;
    logic [7:0] rx_head, load_byte;
    logic load_req;

    mmio_reg_decode #(.BASE_ADDR(BASE_ADDR)) u_dec (
        .req        (bus_req),
        .we         (bus_we),
        .addr       (bus_addr),
        .ld_rx_avail(ld_rx_avail),
        .ld_rx_head (ld_rx_head),
        .ld_tx_space(ld_tx_space),
        .st_rx_pop  (st_rx_pop),
        .st_tx_push (st_tx_push)
    );

    byte_fifo #(.WIDTH(BYTE_W), .DEPTH(DEPTH)) u_rxq (
        .clk  (clk),
        .rst_n(rst_n),
        .push (rx_valid),
        .din  (rx_data),
        .pop  (st_rx_pop),
        .dout (rx_head),
        .empty(rx_empty),
        .full (rx_full)
    );

    byte_fifo #(.WIDTH(BYTE_W), .DEPTH(DEPTH)) u_txq (
        .clk  (clk),
        .rst_n(rst_n),
        .push (st_tx_push),
        .din  (bus_wdata),
        .pop  (tx_ready),
        .dout (tx_data),
        .empty(tx_empty),
        .full (tx_full)
    );

    assign tx_valid = !tx_empty;
    assign load_req = bus_req && !bus_we;

    always_comb begin
        load_byte = '0;
        if (ld_rx_avail) begin
            load_byte = {7'd0, !rx_empty};
        end else if (ld_rx_head) begin
            load_byte = rx_head;
        end else if (ld_tx_space) begin
            load_byte = {7'd0, !tx_full};
        end
    end

    bus_resp_fsm u_resp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_req (load_req),
        .load_byte(load_byte),
        .rvalid   (bus_rvalid),
        .rdata    (bus_rdata)
    );

    // R8: a byte not taken stays presented unchanged
    assert_tx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R3: reading the head does not consume it
    assert_head_nondestructive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_rx_head && !rx_empty && !st_rx_pop) |=> !rx_empty);

    // R5: a dequeue store with an empty queue and no arrival leaves it empty
    assert_pop_empty_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_rx_pop && rx_empty && !rx_valid) |=> rx_empty);

endmodule

// File: tb/serial_mmio_bridge_tb.sv
module serial_mmio_bridge_tb;
    localparam int DEPTH = 4;
    localparam logic [31:0] BASE = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_rvalid;
    logic [7:0]  bus_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    byte unsigned rxq[$];
    byte unsigned txq[$];
    bit           m_rvalid = 1'b0;
    byte unsigned m_rdata = 8'h00;

    always #4 clk = ~clk;

    serial_mmio_bridge #(.DEPTH(DEPTH), .BASE_ADDR(BASE)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        chk(tag, "bus_rvalid", int'(bus_rvalid), int'(m_rvalid));
        chk(tag, "bus_rdata", int'(bus_rdata), int'(m_rdata));
        chk(tag, "tx_valid", int'(tx_valid), int'(txq.size() > 0));
        if (txq.size() > 0) chk(tag, "tx_data", int'(tx_data), int'(txq[0]));
    endtask

    // One cycle: drive after a falling edge, predict from pre-edge state,
    // then compare just after the rising edge.
    task automatic step(input bit req, input bit we, input logic [31:0] addr,
                        input byte unsigned wd, input bit rv, input byte unsigned rd,
                        input bit tr, input string tag);
        bit inwin;
        int off;
        byte unsigned ld;
        bit rx_pop, rx_push, tx_pop, tx_push;
        bus_req = req; bus_we = we; bus_addr = addr; bus_wdata = wd;
        rx_valid = rv; rx_data = rd; tx_ready = tr;
        inwin = (addr[31:3] == BASE[31:3]);
        off = int'(addr[2:0]);
        ld = 8'h00;
        if (inwin) begin
            if (off == 0) ld = (rxq.size() > 0) ? 8'h01 : 8'h00;
            if (off == 1) ld = (rxq.size() > 0) ? rxq[0] : 8'h00;
            if (off == 2) ld = (txq.size() < DEPTH) ? 8'h01 : 8'h00;
        end
        rx_pop  = req && we && inwin && off == 3 && rxq.size() > 0;
        rx_push = rv && rxq.size() < DEPTH;
        tx_pop  = tr && txq.size() > 0;
        tx_push = req && we && inwin && off == 4 && txq.size() < DEPTH;
        @(posedge clk);
        #1;
        if (rx_pop) void'(rxq.pop_front());
        if (rx_push) rxq.push_back(rd);
        if (tx_pop) void'(txq.pop_front());
        if (tx_push) txq.push_back(wd);
        m_rvalid = req && !we;
        m_rdata  = (req && !we) ? ld : 8'h00;
        compare_all(tag);
        @(negedge clk);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic load(input int off, input string tag);
        step(1, 0, BASE + 32'(off), 0, 0, 0, 0, tag);
    endtask
    task automatic store(input int off, input byte unsigned d, input string tag);
        step(1, 1, BASE + 32'(off), d, 0, 0, 0, tag);
    endtask
    task automatic rx_in(input byte unsigned d, input string tag);
        step(0, 0, 0, 0, 1, d, 0, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        compare_all("R1");
        idle("R1");
        // Empty-state status and head reads
        load(0, "R2");
        load(1, "R3");
        load(2, "R4");
        load(0, "R2");
        // Dequeue on empty is ignored
        store(3, 8'hAA, "R5");
        load(0, "R5");
        // Receive bytes, non-destructive head reads
        rx_in(8'h11, "R7");
        rx_in(8'h22, "R7");
        load(0, "R2");
        load(1, "R3");
        load(1, "R3");
        store(3, 0, "R5");
        load(1, "R10");
        // Fill receive queue and overflow
        rx_in(8'h33, "R7");
        rx_in(8'h44, "R7");
        rx_in(8'h55, "R7");
        rx_in(8'h66, "R7");
        // Full queue: arrival dropped even with simultaneous dequeue
        step(1, 1, BASE + 3, 0, 1, 8'h77, 0, "R11");
        for (int i = 0; i < 5; i++) begin
            load(1, "R10");
            store(3, 0, "R10");
        end
        load(0, "R2");
        // Empty queue: dequeue together with arrival keeps the new byte
        step(1, 1, BASE + 3, 0, 1, 8'h88, 0, "R11");
        load(1, "R11");
        store(3, 0, "R5");
        // Transmit: fill with tx_ready low, overflow dropped
        store(4, 8'hA1, "R6");
        load(2, "R4");
        store(4, 8'hA2, "R6");
        store(4, 8'hA3, "R6");
        store(4, 8'hA4, "R6");
        load(2, "R4");
        store(4, 8'hA5, "R6");
        idle("R8");
        // Full transmit: store together with drain is dropped
        step(1, 1, BASE + 4, 8'hB0, 0, 0, 1, "R11");
        step(0, 0, 0, 0, 0, 0, 1, "R8");
        // Push and drain together in a non-full queue
        step(1, 1, BASE + 4, 8'hB1, 0, 0, 1, "R10");
        step(1, 1, BASE + 4, 8'hB2, 0, 0, 1, "R10");
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0, 1, "R8");
        // Empty transmit: drain request ignored while store lands
        step(1, 1, BASE + 4, 8'hC3, 0, 0, 1, "R11");
        step(0, 0, 0, 0, 0, 0, 1, "R8");
        // Unmapped and store-only offsets read zero; stray stores ignored
        rx_in(8'h5A, "R9");
        load(3, "R9");
        load(4, "R9");
        load(5, "R9");
        load(7, "R9");
        step(1, 0, 32'h8000_0009, 0, 0, 0, 0, "R9");
        store(0, 8'hEE, "R9");
        store(1, 8'hEE, "R9");
        store(2, 8'hEE, "R9");
        store(6, 8'hEE, "R9");
        step(1, 1, 32'h8000_000C, 8'hEE, 0, 0, 0, "R9");
        step(1, 1, 32'h8000_000B, 8'hEE, 0, 0, 0, "R9");
        load(1, "R9");
        load(2, "R9");
        idle("R9");
        // Reset returns to empty
        rst_n = 1'b0;
        rxq.delete();
        txq.delete();
        m_rvalid = 1'b0;
        m_rdata = 8'h00;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        compare_all("R1");
        load(0, "R1");
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule